// File: doc/BRIEF.md
# Multichannel DAC Waveform Playback Engine

This block holds a table of DAC codes in an on-chip buffer and replays it one frame at a time. A frame is 1, 2 or 4 consecutive buffer entries. Entry i of a frame goes to DAC channel i, and each code is offered on a request/ready handshake. Each advance event moves playback forward by exactly one frame. An advance event is either a rising edge on the selected hardware trigger or a manual step command. When the frame pointer reaches the programmed buffer depth, it wraps to the start of the buffer.

The host fills the buffer through a load address and a data strobe. The address auto-increments after every stored code. A control byte sets the playback depth in 64-entry blocks, the frame size and the trigger source. A command byte starts or resumes playback, pauses it, rewinds the pointer or steps one frame. If several command bits are set, only the highest set bit acts. While the enhanced-mode enable input is low, the engine is held halted at its defaults and ignores host writes.

Top module: `wavegen_engine`

## Requirements
- R1: A host write with select 0 sets load address bits [7:0], and select 1 sets bits [9:8] from data bits [1:0]. Each buffer write stores the code at the load address and then increments the address, wrapping at 1024.
- R2: Control byte (select 2) bits [3:2] set the frame size: 00 gives one code, 01 gives two, 1x gives four. A frame reads consecutive entries starting at the frame pointer, and code i is sent on channel i in ascending order.
- R3: A request holds its channel and code stable until dac_rdy_i is sampled high. One code is accepted per accepting cycle.
- R4: After the last code of a frame is accepted, the pointer advances by the frame size. It returns to 0 when it reaches (depth+1)*64, where depth is control bits [7:4], or when it reaches 1024.
- R5: Control bits [1:0] select the hardware trigger: 00 none (manual only), 01 timer 0 output, 10 cascaded timer 1/2 output, 11 external pin. Only a rising edge of the selected source advances playback, only while running, and a level held high advances one frame only.
- R6: Command byte (select 3) bit 3 = step, bit 2 = rewind, bit 1 = pause, bit 0 = start/resume. Only the highest set bit is executed.
- R7: Pause clears the running state and keeps the pointer. Triggers are then ignored, and start resumes from the kept position.
- R8: A step command plays one frame whether the engine is running or paused.
- R9: Rewind returns the pointer to 0 and leaves the running state unchanged.
- R10: While enh_en_i is low, the engine halts, control, pointer and load address return to 0, and host and buffer writes are ignored. The buffer contents are kept.
- R11: After reset, no request is pending, the engine is not running and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enh_en_i | input | 1 | Enhanced-mode enable; low halts and clears the engine |
| wr_en_i | input | 1 | Host register write strobe |
| wr_sel_i | input | 2 | Register select: 0 addr low, 1 addr high, 2 control, 3 command |
| wr_data_i | input | 8 | Host write data |
| buf_we_i | input | 1 | Buffer code write strobe |
| buf_data_i | input | 12 | Code to store |
| tmr0_i | input | 1 | Timer 0 output |
| tmr12_i | input | 1 | Cascaded timer 1/2 output |
| ext_trig_i | input | 1 | External trigger pin |
| dac_rdy_i | input | 1 | DAC accepts the current request |
| dac_req_o | output | 1 | DAC write request |
| dac_ch_o | output | 2 | Channel of the requested code |
| dac_code_o | output | 12 | Requested code |
| running_o | output | 1 | Running state |
| frame_ptr_o | output | 10 | Buffer index of the next frame |

## Verification
A step command, or a selected trigger rising edge seen while running, is registered on the clock edge at which it is sampled. The first request of the frame is therefore visible in the following cycle. Each accepting edge presents the next code one cycle later. The pointer moves and the request drops on the edge that accepts the last code, and run state changes are visible one cycle after the command edge. The bench drives every stimulus at the falling edge and samples every result at the next falling edge, so each check falls in exactly the cycle where its result is due. Ignored stimuli are held for several cycles before the absence of a request and the unchanged pointer are checked.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int WG_DEPTH_W = 4;

  typedef enum logic [1:0] {
    SEL_ALO  = 2'd0,
    SEL_AHI  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_CMD  = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_TMR0  = 2'd1,
    SRC_TMR12 = 2'd2,
    SRC_EXT   = 2'd3
  } src_e;

  // command bit positions, highest wins
  localparam int CMD_STEP  = 3;
  localparam int CMD_CLR   = 2;
  localparam int CMD_PAUSE = 1;
  localparam int CMD_START = 0;

  function automatic logic [2:0] frame_len(input logic [1:0] fpf);
    if (fpf[1])      frame_len = 3'd4;
    else if (fpf[0]) frame_len = 3'd2;
    else             frame_len = 3'd1;
  endfunction
endpackage

// File: rtl/wg_regs.sv
module wg_regs
  import wg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  enh_en_i,
  input  logic                  wr_en_i,
  input  logic [1:0]            wr_sel_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  buf_we_i,
  output logic [ADDR_W-1:0]     load_addr_o,
  output logic [WG_DEPTH_W-1:0] depth_o,
  output logic [1:0]            fpf_o,
  output logic [1:0]            src_o,
  output logic                  run_o,
  output logic                  step_o,
  output logic                  clr_o
);
  localparam int HI_W = ADDR_W - 8;

  logic                  wr_act;
  logic [3:0]            cmd_bits;
  logic                  start_p, pause_p;
  logic [ADDR_W-1:0]     addr_q;
  logic [WG_DEPTH_W-1:0] depth_q;
  logic [1:0]            fpf_q, src_q;
  logic                  run_q;

  assign wr_act   = enh_en_i && wr_en_i;
  assign cmd_bits = (wr_act && wr_sel_e'(wr_sel_i) == SEL_CMD) ? wr_data_i[3:0] : 4'd0;

  always_comb begin
    step_o  = 1'b0;
    clr_o   = 1'b0;
    pause_p = 1'b0;
    start_p = 1'b0;
    if (cmd_bits[CMD_STEP])       step_o  = 1'b1;
    else if (cmd_bits[CMD_CLR])   clr_o   = 1'b1;
    else if (cmd_bits[CMD_PAUSE]) pause_p = 1'b1;
    else if (cmd_bits[CMD_START]) start_p = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      depth_q <= '0;
      fpf_q   <= '0;
      src_q   <= '0;
      run_q   <= 1'b0;
    end else if (!enh_en_i) begin
      addr_q  <= '0;
      depth_q <= '0;
      fpf_q   <= '0;
      src_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      if (start_p)      run_q <= 1'b1;
      else if (pause_p) run_q <= 1'b0;
      if (wr_act && wr_sel_e'(wr_sel_i) == SEL_CTRL) begin
        depth_q <= wr_data_i[7:4];
        fpf_q   <= wr_data_i[3:2];
        src_q   <= wr_data_i[1:0];
      end
      if (wr_act && wr_sel_e'(wr_sel_i) == SEL_ALO)      addr_q[7:0]        <= wr_data_i;
      else if (wr_act && wr_sel_e'(wr_sel_i) == SEL_AHI) addr_q[ADDR_W-1:8] <= wr_data_i[HI_W-1:0];
      else if (buf_we_i)                                 addr_q             <= addr_q + 1'b1;
    end
  end

  assign load_addr_o = addr_q;
  assign depth_o     = depth_q;
  assign fpf_o       = fpf_q;
  assign src_o       = src_q;
  assign run_o       = run_q;

  // R7: pause drops the running state
  a_r7_pause_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_p && enh_en_i) |=> !run_q);

  // R1: a plain buffer write advances the load address by one
  a_r1_addr_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_i && enh_en_i && !(wr_act && wr_sel_i[1] == 1'b0))
    |=> addr_q == $past(addr_q) + 1'b1);
endmodule

// File: rtl/wg_trig.sv
module wg_trig
  import wg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enh_en_i,
  input  logic       run_i,
  input  logic [1:0] src_i,
  input  logic       tmr0_i,
  input  logic       tmr12_i,
  input  logic       ext_i,
  output logic       fire_o
);
  logic [3:0] srcs;
  logic       sel, sel_q;

  assign srcs = {ext_i, tmr12_i, tmr0_i, 1'b0};
  assign sel  = srcs[src_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= enh_en_i ? sel : 1'b0;
  end

  assign fire_o = run_i && sel && !sel_q;

  // R5: a held level cannot fire twice in a row
  a_r5_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/wg_buf.sv
module wg_buf #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/wg_seq.sv
module wg_seq
  import wg_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int BLK_LOG2 = 6,
  parameter int CH_W     = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  enh_en_i,
  input  logic                  fire_i,
  input  logic                  step_i,
  input  logic                  clr_i,
  input  logic                  dac_rdy_i,
  input  logic [WG_DEPTH_W-1:0] depth_i,
  input  logic [1:0]            fpf_i,
  output logic                  busy_o,
  output logic [CH_W-1:0]       ch_o,
  output logic [ADDR_W-1:0]     rd_addr_o,
  output logic [ADDR_W-1:0]     ptr_o
);
  localparam int LIM_W = ADDR_W + 1;
  localparam int LEN_W = CH_W + 1;
  localparam logic [LIM_W-1:0] BUF_N = LIM_W'(1) << ADDR_W;

  logic [ADDR_W-1:0] ptr_q;
  logic [CH_W-1:0]   idx_q;
  logic [LEN_W-1:0]  len_q;
  logic              busy_q;
  logic [LIM_W-1:0]  limit_raw, limit, nxt;
  logic              last, start_frame, accept;

  assign limit_raw   = (LIM_W'(depth_i) + LIM_W'(1)) << BLK_LOG2;
  assign limit       = (limit_raw > BUF_N || limit_raw == '0) ? BUF_N : limit_raw;
  assign nxt         = LIM_W'(ptr_q) + LIM_W'(len_q);
  assign last        = (LEN_W'(idx_q) == len_q - LEN_W'(1));
  assign start_frame = (fire_i || step_i) && !busy_q;
  assign accept      = busy_q && dac_rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      idx_q  <= '0;
      len_q  <= LEN_W'(1);
      busy_q <= 1'b0;
    end else if (!enh_en_i || clr_i) begin
      ptr_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_frame) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      len_q  <= LEN_W'(frame_len(fpf_i));
    end else if (accept) begin
      if (last) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
        ptr_q  <= (nxt >= limit) ? '0 : nxt[ADDR_W-1:0];
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign ch_o      = idx_q;
  assign rd_addr_o = ptr_q + ADDR_W'(idx_q);
  assign ptr_o     = ptr_q;

  // R4: a completed frame moves the pointer by its length or wraps to zero
  a_r4_ptr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && last && enh_en_i && !clr_i)
    |=> (ptr_q == '0) || (ptr_q == $past(ptr_q) + ADDR_W'($past(len_q))));

  // R8: a step on an idle sequencer opens a frame
  a_r8_step_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !busy_q && !clr_i && enh_en_i) |=> busy_q);

  // R2: channel index stays inside the frame
  a_r2_ch_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (LEN_W'(idx_q) < len_q));
endmodule

// File: rtl/wavegen_engine.sv
module wavegen_engine
  import wg_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 12,
  parameter int CH_W     = 2,
  parameter int BLK_LOG2 = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enh_en_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [7:0]        wr_data_i,
  input  logic              buf_we_i,
  input  logic [DATA_W-1:0] buf_data_i,
  input  logic              tmr0_i,
  input  logic              tmr12_i,
  input  logic              ext_trig_i,
  input  logic              dac_rdy_i,
  output logic              dac_req_o,
  output logic [CH_W-1:0]   dac_ch_o,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              running_o,
  output logic [ADDR_W-1:0] frame_ptr_o
);
  logic [ADDR_W-1:0]     load_addr, rd_addr;
  logic [WG_DEPTH_W-1:0] depth;
  logic [1:0]            fpf, src;
  logic                  run, step_p, clr_p, fire, busy;

  wg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .enh_en_i, .wr_en_i, .wr_sel_i, .wr_data_i, .buf_we_i,
    .load_addr_o(load_addr), .depth_o(depth), .fpf_o(fpf), .src_o(src),
    .run_o(run), .step_o(step_p), .clr_o(clr_p)
  );

  wg_trig u_trig (
    .clk_i, .rst_ni, .enh_en_i, .run_i(run), .src_i(src),
    .tmr0_i, .tmr12_i, .ext_i(ext_trig_i), .fire_o(fire)
  );

  wg_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk_i, .we_i(buf_we_i && enh_en_i), .waddr_i(load_addr), .wdata_i(buf_data_i),
    .raddr_i(rd_addr), .rdata_o(dac_code_o)
  );

  wg_seq #(.ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2), .CH_W(CH_W)) u_seq (
    .clk_i, .rst_ni, .enh_en_i, .fire_i(fire), .step_i(step_p), .clr_i(clr_p),
    .dac_rdy_i, .depth_i(depth), .fpf_i(fpf), .busy_o(busy), .ch_o(dac_ch_o),
    .rd_addr_o(rd_addr), .ptr_o(frame_ptr_o)
  );

  assign dac_req_o = busy;
  assign running_o = run;

  // R3: an unaccepted request keeps channel and code
  a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_req_o && !dac_rdy_i && enh_en_i && !clr_p)
    |=> dac_req_o && $stable(dac_ch_o) && $stable(dac_code_o));

  // R10: disabled mode forces the idle defaults
  a_r10_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enh_en_i |=> !running_o && !dac_req_o && frame_ptr_o == '0);
endmodule

// File: tb/tb_wavegen_engine.sv
module tb_wavegen_engine;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enh_en = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        buf_we = 1'b0;
  logic [11:0] buf_data = 12'd0;
  logic        tmr0 = 1'b0, tmr12 = 1'b0, ext = 1'b0;
  logic        rdy = 1'b0;
  logic        req;
  logic [1:0]  ch;
  logic [11:0] code;
  logic        running;
  logic [9:0]  fptr;

  always #10 clk = ~clk;

  wavegen_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .enh_en_i(enh_en), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .buf_we_i(buf_we), .buf_data_i(buf_data),
    .tmr0_i(tmr0), .tmr12_i(tmr12), .ext_trig_i(ext), .dac_rdy_i(rdy),
    .dac_req_o(req), .dac_ch_o(ch), .dac_code_o(code), .running_o(running),
    .frame_ptr_o(fptr)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int exp_mem [1024];
  int m_ptr = 0, m_len = 1, m_lim = 64;

  // {ctrl, steps, expected final pointer}
  localparam logic [31:0] VEC [0:5] = '{
    {8'h00, 12'd3,   12'd3},
    {8'h04, 12'd32,  12'd0},
    {8'h08, 12'd17,  12'd4},
    {8'h18, 12'd33,  12'd4},
    {8'h30, 12'd260, 12'd4},
    {8'hFC, 12'd257, 12'd4}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    host_wr(2'd2, v);
    m_len = v[3] ? 4 : (v[2] ? 2 : 1);
    m_lim = (int'(v[7:4]) + 1) * 64;
  endtask

  task automatic play_frame(input string tag, input bit stall);
    for (int i = 0; i < m_len; i++) begin
      chk({tag, " R2 req"}, int'(req), 1);
      chk({tag, " R2 channel"}, int'(ch), i);
      chk({tag, " R2 code"}, int'(code), exp_mem[(m_ptr + i) % 1024]);
      if (stall && i == 0) begin
        repeat (3) @(negedge clk);
        chk({tag, " R3 held req"}, int'(req), 1);
        chk({tag, " R3 held channel"}, int'(ch), 0);
        chk({tag, " R3 held code"}, int'(code), exp_mem[m_ptr % 1024]);
      end
      rdy = 1'b1;
      @(negedge clk);
      rdy = 1'b0;
    end
    m_ptr = m_ptr + m_len;
    if (m_ptr >= m_lim || m_ptr >= 1024) m_ptr = 0;
    chk({tag, " R4 req drops"}, int'(req), 0);
    chk({tag, " R4 pointer"}, int'(fptr), m_ptr);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) exp_mem[i] = (i * 37 + 5) & 12'hFFF;
    repeat (3) @(negedge clk);
    chk("R11 reset req", int'(req), 0);
    chk("R11 reset running", int'(running), 0);
    chk("R11 reset pointer", int'(fptr), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R11 after release req", int'(req), 0);

    // R1: fill the whole buffer through auto-increment
    host_wr(2'd0, 8'h00);
    host_wr(2'd1, 8'h00);
    for (int i = 0; i < 1024; i++) begin
      buf_we = 1'b1; buf_data = 12'(exp_mem[i]);
      @(negedge clk);
    end
    buf_we = 1'b0;

    // table walk: frame sizes, depths, wrap points
    for (int r = 0; r < 6; r++) begin
      set_ctrl(VEC[r][31:24]);
      host_wr(2'd3, 8'h04);
      m_ptr = 0;
      chk("R9 rewind pointer", int'(fptr), 0);
      for (int s = 0; s < int'(VEC[r][23:12]); s++) begin
        host_wr(2'd3, 8'h08);
        play_frame("table", 1'b0);
      end
      chk("R4 table final pointer", int'(fptr), int'(VEC[r][11:0]));
    end

    // R5: trigger ignored while not running
    set_ctrl(8'h01);
    host_wr(2'd3, 8'h04);
    m_ptr = 0;
    tmr0 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 idle trigger req", int'(req), 0);
    tmr0 = 1'b0;
    @(negedge clk);
    chk("R5 idle trigger pointer", int'(fptr), 0);

    host_wr(2'd3, 8'h01);
    chk("R6 start running", int'(running), 1);
    tmr0 = 1'b1;
    @(negedge clk);
    play_frame("R5 timer0", 1'b0);
    repeat (4) @(negedge clk);
    chk("R5 held level one frame", int'(req), 0);
    tmr0 = 1'b0;
    ext = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 unselected source req", int'(req), 0);
    ext = 1'b0;
    @(negedge clk);

    set_ctrl(8'h03);
    ext = 1'b1;
    @(negedge clk);
    play_frame("R5 external", 1'b0);
    ext = 1'b0;
    set_ctrl(8'h02);
    tmr12 = 1'b1;
    @(negedge clk);
    play_frame("R5 timer12", 1'b1);
    tmr12 = 1'b0;
    @(negedge clk);

    // R7 / R8: pause keeps position, step still works, resume continues
    host_wr(2'd3, 8'h02);
    chk("R7 pause running", int'(running), 0);
    tmr12 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 paused trigger req", int'(req), 0);
    chk("R7 paused pointer kept", int'(fptr), m_ptr);
    tmr12 = 1'b0;
    @(negedge clk);
    host_wr(2'd3, 8'h08);
    play_frame("R8 paused step", 1'b0);
    host_wr(2'd3, 8'h01);
    tmr12 = 1'b1;
    @(negedge clk);
    play_frame("R7 resumed", 1'b0);
    tmr12 = 1'b0;
    @(negedge clk);

    // R6: priority of command bits
    host_wr(2'd3, 8'h02);
    host_wr(2'd3, 8'h0F);
    play_frame("R6 step wins", 1'b0);
    chk("R6 start bit ignored", int'(running), 0);
    host_wr(2'd3, 8'h01);
    host_wr(2'd3, 8'h06);
    m_ptr = 0;
    chk("R9 rewind pointer", int'(fptr), 0);
    chk("R9 rewind keeps running", int'(running), 1);
    host_wr(2'd3, 8'h03);
    chk("R6 pause beats start", int'(running), 0);

    // R1: explicit address with high field, then play over it
    host_wr(2'd0, 8'h05);
    host_wr(2'd1, 8'hFE);
    buf_we = 1'b1; buf_data = 12'hABC;
    @(negedge clk);
    buf_data = 12'h123;
    @(negedge clk);
    buf_we = 1'b0;
    exp_mem[12'h205] = 12'hABC;
    exp_mem[12'h206] = 12'h123;
    set_ctrl(8'hF8);
    host_wr(2'd3, 8'h04);
    m_ptr = 0;
    for (int s = 0; s < 129; s++) begin
      host_wr(2'd3, 8'h08);
      play_frame("R1 walk", 1'b0);
    end
    chk("R1 pointer at loaded block", int'(fptr), 12'h204);
    host_wr(2'd3, 8'h08);
    play_frame("R1 loaded codes", 1'b0);

    // R10: leaving enhanced mode
    host_wr(2'd3, 8'h01);
    enh_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 halted", int'(running), 0);
    chk("R10 pointer cleared", int'(fptr), 0);
    chk("R10 no request", int'(req), 0);
    host_wr(2'd2, 8'h08);
    host_wr(2'd3, 8'h01);
    chk("R10 start ignored", int'(running), 0);
    enh_en = 1'b1;
    @(negedge clk);
    m_ptr = 0; m_len = 1; m_lim = 64;
    host_wr(2'd3, 8'h08);
    play_frame("R10 defaults after re-enable", 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule